// File: doc/BRIEF.md
# Sequential RGB Palette DAC

This block is a 256-entry colour lookup table that software loads through two 32-bit write registers. A write to the index register selects the entry to load. Writes to the data register then supply the colour one component at a time: the first write is red, the second green and the third blue. After the blue write the block moves on to the next entry by itself, so a whole palette can be streamed after one index write. Each entry keeps its 8-bit red, green and blue values. It also keeps a packed output word, ready for the display format chosen at the `fmt_sel` and `bgr_sel` inputs.

A pixel path looks up packed words through a valid/ready request channel, and the results come back on a valid/ready result channel. A request is taken in a cycle where `lk_valid` and `lk_ready` are both high. Its result appears one clock later, with `out_valid` high. The result stays on the port, unchanged, until a cycle in which `out_ready` is high. While a result waits, `lk_ready` is low, so back-pressure from the result side stalls the request side.

When the format inputs change, the block regenerates every packed word in a sweep that handles one entry per cycle. While this happens it raises `busy` and refuses lookups.

Top module: `palette_dac`

## Requirements
- R1: A write (`wr_en` high) to byte offset 0 loads the entry index from `wr_data[31:24]` and sets the component phase back to red.
- R2: A write to byte offset 4 takes the component value from `wr_data[31:24]`. Successive such writes store red, then green, then blue into the entry at the current index.
- R3: After the blue write the index advances by one, wrapping from 255 to 0, and the next data write is again red.
- R4: A write to any offset other than 0 and 4 changes neither the index, nor the phase, nor any entry.
- R5: The packed word depends on `fmt_sel`. Code 0 gives 8-bit: red[7:5] in bits 7:5, green[7:5] in bits 4:2 and blue[7:6] in bits 1:0. Code 1 gives 15-bit: red[7:3] in bits 14:10, green[7:3] in bits 9:5 and blue[7:3] in bits 4:0. Code 2 gives 16-bit: red[7:3] in bits 15:11, green[7:2] in bits 10:5 and blue[7:3] in bits 4:0. Code 3 gives 32-bit: red in bits 23:16, green in 15:8 and blue in 7:0. In code 3 only, `bgr_sel`=1 swaps the red and blue bytes. All bits above each field are zero.
- R6: The packed word of an entry is recomputed on every component write. After only the red write, the entry reads as the new red combined with the green and blue the entry already held.
- R7: After reset every entry holds red, green and blue of zero, so every lookup returns 0. Reset also leaves `busy` and `out_valid` low and `lk_ready` high.
- R8: A change of `fmt_sel` or `bgr_sel` raises `busy` at once. `busy` then stays high for 256 further clock cycles while every packed word is rebuilt in the new format, and `lk_ready` is low whenever `busy` is high.
- R9: An accepted lookup presents its packed word on `out_word` with `out_valid` high one clock later. While `out_ready` is low the result holds steady and `lk_ready` stays low.
- R10: When a component write and the format sweep touch the same entry in the same cycle, the entry ends up holding the packed form of the newly written colour in the new format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| fmt_sel | input | 2 | Output format code (see R5) |
| bgr_sel | input | 1 | Swap red and blue bytes in 32-bit format |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle if valid |
| lk_index | input | 8 | Pixel index to look up |
| out_valid | output | 1 | Lookup result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Packed output word |
| busy | output | 1 | Format sweep pending or running |

## Verification
A component write and the format sweep can both write the packed word of the same entry in one clock. To provoke this, the red and green of an entry are loaded first. The format is then changed, and the blue write is timed so that its clock edge is the one at which the sweep counter reaches that entry. The entry is then looked up after `busy` falls. The check passes only if the result is the new colour packed in the new format, and not the stale colour repacked by the sweep.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COMP_W = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_15 = 2'd1,
    FMT_16 = 2'd2,
    FMT_32 = 2'd3
  } fmt_t;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  function automatic logic [WORD_W-1:0] pack_px(
    input logic [COMP_W-1:0] r,
    input logic [COMP_W-1:0] g,
    input logic [COMP_W-1:0] b,
    input fmt_t              f,
    input logic              swap
  );
    logic [WORD_W-1:0] w;
    w = '0;
    case (f)
      FMT_8:  w[7:0]   = {r[7:5], g[7:5], b[7:6]};
      FMT_15: w[14:0]  = {r[7:3], g[7:3], b[7:3]};
      FMT_16: w[15:0]  = {r[7:3], g[7:2], b[7:3]};
      default: w[23:0] = swap ? {b, g, r} : {r, g, b};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 8,
  parameter int OFS_INDEX = 0,
  parameter int OFS_DATA  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              comp_we,
  output phase_t            comp_sel,
  output logic [IDX_W-1:0]  comp_idx,
  output logic [COMP_W-1:0] comp_val
);
  logic            hit_idx, hit_dat;
  logic [IDX_W-1:0] idx_q;
  phase_t          ph_q;

  assign hit_idx  = wr_en && (wr_addr == ADDR_W'(OFS_INDEX));
  assign hit_dat  = wr_en && (wr_addr == ADDR_W'(OFS_DATA));
  assign comp_we  = hit_dat;
  assign comp_sel = ph_q;
  assign comp_idx = idx_q;
  assign comp_val = wr_data[31 -: COMP_W];

  // index width equals log2 of entry count, so the increment wraps naturally
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (hit_idx) begin
      idx_q <= wr_data[31 -: IDX_W];
      ph_q  <= PH_RED;
    end else if (hit_dat) begin
      case (ph_q)
        PH_RED:  ph_q <= PH_GRN;
        PH_GRN:  ph_q <= PH_BLU;
        default: begin
          ph_q  <= PH_RED;
          idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_idx |=> (idx_q == $past(wr_data[31 -: IDX_W])) && (ph_q == PH_RED)); // R1
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3); // R2
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat && ph_q == PH_BLU) |=> (ph_q == PH_RED) && (idx_q == IDX_W'($past(idx_q) + 1))); // R3
  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_idx || hit_dat) |=> $stable(idx_q) && $stable(ph_q)); // R4
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_we,
  input  phase_t            comp_sel,
  input  logic [IDX_W-1:0]  comp_idx,
  input  logic [COMP_W-1:0] comp_val,
  input  fmt_t              cfg_fmt,
  input  logic              cfg_bgr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [COMP_W-1:0] r_mem [ENTRIES];
  logic [COMP_W-1:0] g_mem [ENTRIES];
  logic [COMP_W-1:0] b_mem [ENTRIES];
  logic [WORD_W-1:0] w_mem [ENTRIES];

  fmt_t             app_fmt;
  logic             app_bgr;
  logic             sweeping;
  logic [IDX_W-1:0] sw_cnt;
  logic             cfg_diff;
  logic [COMP_W-1:0] nr, ng, nb;

  assign cfg_diff = (cfg_fmt != app_fmt) || (cfg_bgr != app_bgr);
  assign busy     = sweeping || cfg_diff;
  assign rd_word  = w_mem[rd_idx];

  always_comb begin
    nr = r_mem[comp_idx];
    ng = g_mem[comp_idx];
    nb = b_mem[comp_idx];
    case (comp_sel)
      PH_RED:  nr = comp_val;
      PH_GRN:  ng = comp_val;
      default: nb = comp_val;
    endcase
  end

  // sweep control: a config change (re)starts from entry 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_fmt  <= FMT_8;
      app_bgr  <= 1'b0;
      sweeping <= 1'b0;
      sw_cnt   <= '0;
    end else if (cfg_diff) begin
      app_fmt  <= cfg_fmt;
      app_bgr  <= cfg_bgr;
      sweeping <= 1'b1;
      sw_cnt   <= '0;
    end else if (sweeping) begin
      sw_cnt <= sw_cnt + 1'b1;
      if (sw_cnt == LAST) sweeping <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        r_mem[i] <= '0;
        g_mem[i] <= '0;
        b_mem[i] <= '0;
        w_mem[i] <= '0;
      end
    end else begin
      if (sweeping && !cfg_diff)
        w_mem[sw_cnt] <= pack_px(r_mem[sw_cnt], g_mem[sw_cnt], b_mem[sw_cnt], app_fmt, app_bgr);
      // a component write is ordered last so it wins a same-entry collision
      if (comp_we) begin
        r_mem[comp_idx] <= nr;
        g_mem[comp_idx] <= ng;
        b_mem[comp_idx] <= nb;
        w_mem[comp_idx] <= pack_px(nr, ng, nb, app_fmt, app_bgr);
      end
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && !cfg_diff && sw_cnt != LAST) |=> sweeping && (sw_cnt == IDX_W'($past(sw_cnt) + 1))); // R8
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && !cfg_diff && sw_cnt == LAST) |=> !sweeping); // R8
  AST_CHANGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_diff |=> sweeping && (sw_cnt == '0)); // R8
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_index,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic take;

  assign lk_ready = !busy && (!out_valid || out_ready);
  assign take     = lk_valid && lk_ready;
  assign rd_idx   = lk_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= rd_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word)); // R9
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_ready); // R8
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import pal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ENTRIES   = 256,
  parameter int OFS_INDEX = 0,
  parameter int OFS_DATA  = 4,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        fmt_sel,
  input  logic              bgr_sel,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic              busy
);
  logic              comp_we;
  phase_t            comp_sel;
  logic [IDX_W-1:0]  comp_idx;
  logic [COMP_W-1:0] comp_val;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  fmt_t              fmt_in;

  assign fmt_in = fmt_t'(fmt_sel);

  pal_loader #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_INDEX(OFS_INDEX), .OFS_DATA(OFS_DATA)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .comp_we(comp_we), .comp_sel(comp_sel), .comp_idx(comp_idx), .comp_val(comp_val)
  );

  pal_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .comp_sel(comp_sel),
    .comp_idx(comp_idx), .comp_val(comp_val), .cfg_fmt(fmt_in), .cfg_bgr(bgr_sel),
    .rd_idx(rd_idx), .rd_word(rd_word), .busy(busy)
  );

  pal_lookup #(.IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .busy(busy), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_index(lk_index), .rd_idx(rd_idx), .rd_word(rd_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );
endmodule

// File: tb/sim_palette_dac.sv
`timescale 1ns/1ps
module sim_palette_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        bgr_sel = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [7:0]  lk_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] m_idx = 0;
  int         m_ph = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  palette_dac u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fmt_sel(fmt_sel), .bgr_sel(bgr_sel), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_index(lk_index), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .busy(busy)
  );

  function automatic logic [31:0] expect_word(int i);
    logic [7:0] r, g, b;
    r = mr[i]; g = mg[i]; b = mb[i];
    case (fmt_sel)
      2'd0: return 32'((r >> 5) << 5 | (g >> 5) << 2 | (b >> 6));
      2'd1: return 32'((r >> 3) << 10 | (g >> 3) << 5 | (b >> 3));
      2'd2: return 32'((r >> 3) << 11 | (g >> 2) << 5 | (b >> 3));
      default: return bgr_sel ? {8'h0, b, g, r} : {8'h0, r, g, b};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = {v, 24'h5a5a5a};
    if (a == 8'd0) begin m_idx = v; m_ph = 0; end
    else if (a == 8'd4) begin
      case (m_ph)
        0: mr[m_idx] = v;
        1: mg[m_idx] = v;
        default: mb[m_idx] = v;
      endcase
      if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
      else m_ph++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(logic [7:0] i, string req);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    exp_q.push_back(expect_word(i));
    tag_q.push_back(req);
    lk_valid = 1'b1; lk_index = i;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle;
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  // monitor: pops expected items as results are consumed
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: actual unexpected result %h expected none", out_word);
      end else begin
        check(tag_q.pop_front(), out_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 busy", 32'(busy), 32'd0);
    check("R7 out_valid", 32'(out_valid), 32'd0);
    check("R7 lk_ready", 32'(lk_ready), 32'd1);
    lookup(8'd0, "R7");
    lookup(8'd255, "R7");
    lookup(8'd77, "R7");
    drain();

    // R1 R2 R6: partial entry after red only
    reg_wr(8'd0, 8'd5);
    reg_wr(8'd4, 8'hE0);
    lookup(8'd5, "R6");
    reg_wr(8'd4, 8'h9C);
    reg_wr(8'd4, 8'hC3);
    lookup(8'd5, "R2");
    // R3: continues at entry 6
    reg_wr(8'd4, 8'h21);
    reg_wr(8'd4, 8'h42);
    reg_wr(8'd4, 8'h84);
    lookup(8'd6, "R3");
    // R3 wrap from 255 to 0
    reg_wr(8'd0, 8'd255);
    reg_wr(8'd4, 8'hFF);
    reg_wr(8'd4, 8'h80);
    reg_wr(8'd4, 8'h40);
    reg_wr(8'd4, 8'hA0);
    lookup(8'd255, "R3");
    lookup(8'd0, "R3");
    // R1 index reload mid-entry resets phase
    reg_wr(8'd0, 8'd30);
    reg_wr(8'd4, 8'h11);
    reg_wr(8'd0, 8'd31);
    reg_wr(8'd4, 8'hF0);
    lookup(8'd30, "R1");
    lookup(8'd31, "R1");
    drain();

    // R4: writes elsewhere are ignored
    reg_wr(8'd0, 8'd10);
    reg_wr(8'd4, 8'h66);
    reg_wr(8'd8, 8'hAA);
    reg_wr(8'd1, 8'd99);
    reg_wr(8'd4, 8'h77);
    reg_wr(8'd4, 8'hE8);
    lookup(8'd10, "R4");
    lookup(8'd11, "R4");
    lookup(8'd99, "R4");
    drain();

    // R8: format change sweep length and blocking
    begin
      int n = 0;
      @(negedge clk);
      fmt_sel = 2'd3;
      #1;
      check("R8 busy at change", 32'(busy), 32'd1);
      @(negedge clk);
      check("R8 lk_ready while busy", 32'(lk_ready), 32'd0);
      while (busy && n < 2000) begin n++; @(negedge clk); end
      check("R8 sweep cycles", 32'(n), 32'd256);
    end
    lookup(8'd5, "R5 32");
    lookup(8'd6, "R5 32");
    lookup(8'd255, "R8");
    lookup(8'd10, "R8");
    drain();
    @(negedge clk); bgr_sel = 1'b1;
    wait_idle();
    lookup(8'd5, "R5 bgr");
    lookup(8'd0, "R5 bgr");
    drain();
    @(negedge clk); fmt_sel = 2'd1;
    wait_idle();
    lookup(8'd5, "R5 15");
    lookup(8'd6, "R5 15");
    drain();
    @(negedge clk); fmt_sel = 2'd2;
    wait_idle();
    lookup(8'd5, "R5 16");
    lookup(8'd255, "R5 16");
    lookup(8'd10, "R5 16");
    drain();

    // R10: write and sweep hit entry 20 at the same edge
    reg_wr(8'd0, 8'd20);
    reg_wr(8'd4, 8'hB4);
    reg_wr(8'd4, 8'h5D);
    @(negedge clk);
    fmt_sel = 2'd3; bgr_sel = 1'b0;
    @(negedge clk);
    repeat (20) @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd4; wr_data = 32'h3E000000;
    mb[20] = 8'h3E; m_ph = 0; m_idx = 8'd21;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    lookup(8'd20, "R10");
    drain();

    // R9: back-pressure holds the result
    begin
      logic [31:0] held;
      @(negedge clk);
      out_ready = 1'b0;
      lookup(8'd5, "R9");
      check("R9 valid held", 32'(out_valid), 32'd1);
      check("R9 lk_ready low", 32'(lk_ready), 32'd0);
      held = out_word;
      repeat (3) @(negedge clk);
      check("R9 still valid", 32'(out_valid), 32'd1);
      check("R9 stable word", out_word, held);
      out_ready = 1'b1;
      drain();
      check("R9 released", 32'(out_valid), 32'd0);
    end
    check("R9 queue empty", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule